// File: doc/BRIEF.md
# Three-Port Masked Register File

This block holds a small array of byte-wide registers that three independent requesters share. The first port is an external bus port. It always writes a whole byte. The second and third ports serve two internal client modules. Each internal port writes through its own bit-enable mask, so a client can change one bit, several bits or the whole byte in place. It does not need to read the register first, and it does not need to coordinate with the other client.

All three ports can read at any time. Reads are registered and return data one cycle after the address is presented.

When two or three ports write the same register in one cycle, the next value is resolved bit by bit with a fixed priority: the external port first, then client A, then client B. A bit that no port enables keeps its value. Writes to disjoint bits of one register from different ports all take effect together.

The block has no state machine. Its only sequential parts are the storage array and the three read-data registers.

Top module: `rf3_masked_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register and all three read-data outputs to zero.
- R2: Each port's read data is registered. The data presented after clock edge k is the content, before any write at edge k, of the register addressed when edge k was sampled (read-before-write).
- R3: A port 0 write replaces all eight bits of the addressed register with the port 0 write data.
- R4: A port 1 or port 2 write updates only the bits whose write-mask bit is 1. Every bit whose mask bit is 0 keeps its previous value.
- R5: When several ports enable the same bit of the same register in one cycle, port 0 wins over port 1, and port 1 wins over port 2.
- R6: When ports write disjoint bits of the same register in one cycle, every one of those bits takes its own port's data.
- R7: A write with an all-zero mask leaves the storage unchanged.
- R8: The address width is $clog2(NREGS+1), which is 5 bits for the default of 16 registers. A write to an address of NREGS or above changes no register. A read from such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| p0_addr | input | AW | Port 0 (external) address |
| p0_we | input | 1 | Port 0 write enable |
| p0_wdata | input | 8 | Port 0 write data, full byte |
| p0_rdata | output | 8 | Port 0 registered read data |
| p1_addr | input | AW | Port 1 (client A) address |
| p1_we | input | 1 | Port 1 write enable |
| p1_wdata | input | 8 | Port 1 write data |
| p1_wmask | input | 8 | Port 1 bit-enable mask, 1 = bit is written |
| p1_rdata | output | 8 | Port 1 registered read data |
| p2_addr | input | AW | Port 2 (client B) address |
| p2_we | input | 1 | Port 2 write enable |
| p2_wdata | input | 8 | Port 2 write data |
| p2_wmask | input | 8 | Port 2 bit-enable mask, 1 = bit is written |
| p2_rdata | output | 8 | Port 2 registered read data |

## Verification
Read data is due one clock edge after its address is sampled. A write lands at the same edge, so its effect can first be seen on a read issued in the following cycle, two edges after the write was presented. The bench drives every input on the falling edge. At that moment it computes each port's expected read data from its model, taken before the cycle's writes are applied, and then it applies the writes to the model. It compares all three read outputs at the next falling edge, which gives a full half period of settling on each side of the rising edge. Directed sequences cover the same-cycle collision, the disjoint-mask merge, the zero-mask write, out-of-range addresses and the same-address read-during-write. Seeded random traffic concentrated on a few addresses then exercises the priority merge heavily.

// File: rtl/rf3_pkg.sv
package rf3_pkg;
    localparam int DATA_W    = 8;
    localparam int NUM_PORTS = 3;

    typedef logic [DATA_W-1:0] byte_t;

    // Resolve one bit from three requesters, highest priority first.
    function automatic logic pick_bit(
        input logic cur,
        input logic e0, input logic v0,
        input logic e1, input logic v1,
        input logic e2, input logic v2
    );
        if (e0)      return v0;
        else if (e1) return v1;
        else if (e2) return v2;
        else         return cur;
    endfunction
endpackage

// File: rtl/rf3_wr_decode.sv
module rf3_wr_decode
    import rf3_pkg::*;
#(
    parameter int NREGS = 16,
    parameter int AW    = $clog2(NREGS + 1)
) (
    input  logic                          we,
    input  logic [AW-1:0]                 addr,
    input  byte_t                         mask,
    output logic [NREGS-1:0][DATA_W-1:0]  bit_en
);
    // One row of bit enables per register. An address with no matching
    // row (out of range) enables nothing.
    for (genvar r = 0; r < NREGS; r++) begin : g_row
        always_comb begin
            if (we && (addr == AW'(r))) bit_en[r] = mask;
            else                        bit_en[r] = '0;
        end
    end
endmodule

// File: rtl/rf3_bit_merge.sv
module rf3_bit_merge
    import rf3_pkg::*;
(
    input  byte_t cur,
    input  byte_t en0,
    input  byte_t en1,
    input  byte_t en2,
    input  byte_t d0,
    input  byte_t d1,
    input  byte_t d2,
    output byte_t nxt
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign nxt[b] = pick_bit(cur[b], en0[b], d0[b], en1[b], d1[b], en2[b], d2[b]);
    end
endmodule

// File: rtl/rf3_rd_port.sv
module rf3_rd_port
    import rf3_pkg::*;
#(
    parameter int NREGS = 16,
    parameter int AW    = $clog2(NREGS + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [AW-1:0]                 addr,
    input  logic [NREGS-1:0][DATA_W-1:0]  regs,
    output byte_t                         rdata
);
    localparam logic [AW-1:0] LIMIT = AW'(NREGS);

    byte_t sel;

    always_comb begin
        sel = '0;
        for (int r = 0; r < NREGS; r++) begin
            if (addr == AW'(r)) sel = regs[r];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= sel;
    end

    assert_oor_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(addr) >= LIMIT) |-> (rdata == '0))
        else $error("out-of-range read returned nonzero data");
endmodule

// File: rtl/rf3_masked_regfile.sv
module rf3_masked_regfile
    import rf3_pkg::*;
#(
    parameter int NREGS = 16,
    parameter int AW    = $clog2(NREGS + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  p0_addr,
    input  logic           p0_we,
    input  logic [7:0]     p0_wdata,
    output logic [7:0]     p0_rdata,
    input  logic [AW-1:0]  p1_addr,
    input  logic           p1_we,
    input  logic [7:0]     p1_wdata,
    input  logic [7:0]     p1_wmask,
    output logic [7:0]     p1_rdata,
    input  logic [AW-1:0]  p2_addr,
    input  logic           p2_we,
    input  logic [7:0]     p2_wdata,
    input  logic [7:0]     p2_wmask,
    output logic [7:0]     p2_rdata
);
    logic [NREGS-1:0][DATA_W-1:0] regs_q;
    logic [NREGS-1:0][DATA_W-1:0] regs_d;
    logic [NREGS-1:0][DATA_W-1:0] en0;
    logic [NREGS-1:0][DATA_W-1:0] en1;
    logic [NREGS-1:0][DATA_W-1:0] en2;

    rf3_wr_decode #(.NREGS(NREGS), .AW(AW)) u_dec0 (
        .we(p0_we), .addr(p0_addr), .mask('1), .bit_en(en0));
    rf3_wr_decode #(.NREGS(NREGS), .AW(AW)) u_dec1 (
        .we(p1_we), .addr(p1_addr), .mask(p1_wmask), .bit_en(en1));
    rf3_wr_decode #(.NREGS(NREGS), .AW(AW)) u_dec2 (
        .we(p2_we), .addr(p2_addr), .mask(p2_wmask), .bit_en(en2));

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        rf3_bit_merge u_merge (
            .cur(regs_q[r]),
            .en0(en0[r]), .en1(en1[r]), .en2(en2[r]),
            .d0(p0_wdata), .d1(p1_wdata), .d2(p2_wdata),
            .nxt(regs_d[r])
        );

        always_ff @(posedge clk) begin
            if (rst) regs_q[r] <= '0;
            else     regs_q[r] <= regs_d[r];
        end

        // Bits no port enabled must not move (R4, R7, R8 writes).
        assert_unenabled_hold_R4: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (((regs_q[r] ^ $past(regs_q[r])) &
                       ~$past(en0[r] | en1[r] | en2[r])) == '0))
            else $error("unenabled bit changed in register %0d", r);

        assert_port0_full_byte_R3: assert property (@(posedge clk) disable iff (rst)
            (en0[r] != '0) |=> (regs_q[r] == $past(p0_wdata)))
            else $error("port 0 write did not take full byte in register %0d", r);

        assert_port1_over_port2_R5: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (((regs_q[r] ^ $past(p1_wdata)) &
                       $past(en1[r] & ~en0[r])) == '0))
            else $error("port 1 enabled bit lost in register %0d", r);

        assert_port2_lowest_R6: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (((regs_q[r] ^ $past(p2_wdata)) &
                       $past(en2[r] & ~en1[r] & ~en0[r])) == '0))
            else $error("port 2 enabled bit lost in register %0d", r);
    end

    rf3_rd_port #(.NREGS(NREGS), .AW(AW)) u_rd0 (
        .clk(clk), .rst(rst), .addr(p0_addr), .regs(regs_q), .rdata(p0_rdata));
    rf3_rd_port #(.NREGS(NREGS), .AW(AW)) u_rd1 (
        .clk(clk), .rst(rst), .addr(p1_addr), .regs(regs_q), .rdata(p1_rdata));
    rf3_rd_port #(.NREGS(NREGS), .AW(AW)) u_rd2 (
        .clk(clk), .rst(rst), .addr(p2_addr), .regs(regs_q), .rdata(p2_rdata));

    assert_reset_clears_R1: assert property (@(posedge clk)
        $past(rst) |-> ((regs_q == '0) && (p0_rdata == '0) &&
                        (p1_rdata == '0) && (p2_rdata == '0)))
        else $error("reset did not clear state");
endmodule

// File: tb/sim_rf3_masked_regfile.sv
module sim_rf3_masked_regfile;
    localparam int NREGS = 16;
    localparam int AW    = $clog2(NREGS + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] p0_addr = '0, p1_addr = '0, p2_addr = '0;
    logic          p0_we = 1'b0, p1_we = 1'b0, p2_we = 1'b0;
    logic [7:0]    p0_wdata = '0, p1_wdata = '0, p2_wdata = '0;
    logic [7:0]    p1_wmask = '0, p2_wmask = '0;
    logic [7:0]    p0_rdata, p1_rdata, p2_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] model [NREGS];

    always #10 clk = ~clk;

    rf3_masked_regfile #(.NREGS(NREGS), .AW(AW)) u0 (
        .clk(clk), .rst(rst),
        .p0_addr(p0_addr), .p0_we(p0_we), .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
        .p1_addr(p1_addr), .p1_we(p1_we), .p1_wdata(p1_wdata), .p1_wmask(p1_wmask),
        .p1_rdata(p1_rdata),
        .p2_addr(p2_addr), .p2_we(p2_we), .p2_wdata(p2_wdata), .p2_wmask(p2_wmask),
        .p2_rdata(p2_rdata));

    function automatic logic [7:0] rd_model(input logic [AW-1:0] a);
        if (int'(a) < NREGS) return model[int'(a)];
        return 8'h00;
    endfunction

    // Apply a masked write to the model; later calls override earlier ones.
    function automatic void apply_wr(input logic [AW-1:0] a, input logic we,
                                     input logic [7:0] d, input logic [7:0] m);
        if (we && int'(a) < NREGS)
            model[int'(a)] = (model[int'(a)] & ~m) | (d & m);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    // Drive on a falling edge, sample at the next falling edge.
    task automatic cyc(input string tag,
                       input logic [AW-1:0] a0, input logic w0, input logic [7:0] d0,
                       input logic [AW-1:0] a1, input logic w1, input logic [7:0] d1,
                       input logic [7:0] m1,
                       input logic [AW-1:0] a2, input logic w2, input logic [7:0] d2,
                       input logic [7:0] m2);
        logic [7:0] e0, e1, e2;
        p0_addr = a0; p0_we = w0; p0_wdata = d0;
        p1_addr = a1; p1_we = w1; p1_wdata = d1; p1_wmask = m1;
        p2_addr = a2; p2_we = w2; p2_wdata = d2; p2_wmask = m2;
        e0 = rd_model(a0); e1 = rd_model(a1); e2 = rd_model(a2);
        apply_wr(a2, w2, d2, m2);
        apply_wr(a1, w1, d1, m1);
        apply_wr(a0, w0, d0, 8'hFF);
        @(negedge clk);
        check(tag, "p0_rdata", p0_rdata, e0);
        check(tag, "p1_rdata", p1_rdata, e1);
        check(tag, "p2_rdata", p2_rdata, e2);
    endtask

    task automatic rd3(input string tag, input logic [AW-1:0] a0,
                       input logic [AW-1:0] a1, input logic [AW-1:0] a2);
        cyc(tag, a0, 0, 8'h00, a1, 0, 8'h00, 8'h00, a2, 0, 8'h00, 8'h00);
    endtask

    initial begin
        for (int i = 0; i < NREGS; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", "p0_rdata after reset", p0_rdata, 8'h00);
        check("R1", "p1_rdata after reset", p1_rdata, 8'h00);
        check("R1", "p2_rdata after reset", p2_rdata, 8'h00);
        for (int i = 0; i < NREGS; i++) rd3("R1", AW'(i), AW'(i), AW'(i));

        // R3: full-byte external write, observed on the internal ports
        cyc("R3", 5'd3, 1, 8'hA5, 5'd0, 0, 8'h00, 8'h00, 5'd0, 0, 8'h00, 8'h00);
        rd3("R3", 5'd3, 5'd3, 5'd3);
        // R4: single-bit set on port 1, single-bit clear on port 2
        cyc("R4", 5'd0, 0, 8'h00, 5'd3, 1, 8'hFF, 8'h10, 5'd1, 0, 8'h00, 8'h00);
        rd3("R4", 5'd3, 5'd3, 5'd3);
        cyc("R4", 5'd0, 0, 8'h00, 5'd1, 0, 8'h00, 8'h00, 5'd3, 1, 8'h00, 8'h01);
        rd3("R4", 5'd3, 5'd3, 5'd3);
        // R5: all three ports hit register 5 with full masks
        cyc("R5", 5'd5, 1, 8'h3C, 5'd5, 1, 8'hC3, 8'hFF, 5'd5, 1, 8'h99, 8'hFF);
        rd3("R5", 5'd5, 5'd5, 5'd5);
        // R5: ports 1 and 2 overlap on the low nibble
        cyc("R5", 5'd0, 0, 8'h00, 5'd7, 1, 8'h05, 8'h0F, 5'd7, 1, 8'hFA, 8'h0F);
        rd3("R5", 5'd7, 5'd7, 5'd7);
        // R6: disjoint nibbles from ports 1 and 2 in one cycle
        cyc("R6", 5'd0, 0, 8'h00, 5'd6, 1, 8'hA0, 8'hF0, 5'd6, 1, 8'h0B, 8'h0F);
        rd3("R6", 5'd6, 5'd6, 5'd6);
        // R6: port 0 on a different register alongside
        cyc("R6", 5'd9, 1, 8'h77, 5'd6, 1, 8'h00, 8'h80, 5'd6, 1, 8'hFF, 8'h01);
        rd3("R6", 5'd6, 5'd9, 5'd6);
        // R7: write strobes with empty masks
        cyc("R7", 5'd0, 0, 8'h00, 5'd3, 1, 8'h00, 8'h00, 5'd5, 1, 8'hFF, 8'h00);
        rd3("R7", 5'd3, 5'd5, 5'd3);
        // R8: out-of-range writes, reads of out-of-range and aliased rows
        cyc("R8", 5'd20, 1, 8'hEE, 5'd19, 1, 8'hEE, 8'hFF, 5'd31, 1, 8'hEE, 8'hFF);
        rd3("R8", 5'd20, 5'd4, 5'd16);
        rd3("R8", 5'd3, 5'd15, 5'd0);
        // R2: read-before-write at the same address, then the new value
        cyc("R2", 5'd2, 1, 8'h5A, 5'd2, 0, 8'h00, 8'h00, 5'd2, 0, 8'h00, 8'h00);
        cyc("R2", 5'd2, 0, 8'h00, 5'd2, 1, 8'h0F, 8'h0F, 5'd2, 0, 8'h00, 8'h00);
        rd3("R2", 5'd2, 5'd2, 5'd2);

        // Random traffic focused on few registers to force collisions
        void'($urandom(32'd1357));
        for (int n = 0; n < 3000; n++) begin
            logic [AW-1:0] a [3];
            for (int k = 0; k < 3; k++) begin
                if ($urandom_range(0, 9) == 0) a[k] = AW'($urandom_range(0, 31));
                else                           a[k] = AW'($urandom_range(0, 3));
            end
            cyc("R5", a[0], 1'($urandom), 8'($urandom),
                      a[1], 1'($urandom), 8'($urandom), 8'($urandom),
                      a[2], 1'($urandom), 8'($urandom), 8'($urandom));
        end
        for (int i = 0; i < NREGS; i++) rd3("R6", AW'(i), AW'(i), AW'(i));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule